// File: doc/BRIEF.md
# Core Cluster Boot Vector and Power-Down Control Registers

This block is a small register file that sits beside a cluster of processor cores. For every core it keeps a 64-bit boot address, built from a lower and an upper 32-bit word. It drives that address to the core continuously, so a core that leaves reset fetches from whatever software last programmed. A shared power-control word holds one power-down request bit per core. The block drives each request bit to the power controller as a status line. It also combines the bit with the core's live wait-for-interrupt level to form a registered "ready to power down" signal.

A host reaches the registers over a 32-bit word bus with separate request and response channels, each using a valid/ready handshake. A request is taken in the cycle where `req_valid` and `req_ready` are both high. Exactly one response follows in the next cycle. That response stays on the bus, with unchanged data, until the host raises `rsp_ready`. While a response is waiting, `req_ready` stays low, so the host sees back-pressure and at most one transaction is ever in flight. Writes take effect on the same clock edge that accepts them. The wait-for-interrupt inputs are level signals that the block samples on every clock.

Top module: `cc_core_ctl`

## Requirements
- R1: After reset, every core's boot address is 0x0000_0000_FFFF_0000, `pd_ready` and `pwr_status` are all zero, `rsp_valid` is low and `req_ready` is high.
- R2: The lower boot word of core n is at byte offset 0x40 + 8n and the upper word is at 0x44 + 8n. Both words read back what was last written to them.
- R3: Core n's boot address appears on `reset_vec[64n+63:64n]` as {upper, lower}. It shows the new value in the cycle after the write is accepted.
- R4: A boot address changes only when a write to one of its own two words is accepted. Writes to other offsets leave it unchanged.
- R5: The power-control word is at offset 0x90. Bit i is core i's power-down request. Bits 31:4 are ignored on write and read as zero.
- R6: `pd_ready[i]` is registered. At each clock edge it takes the AND of request bit i and `wfi_in[i]` as they were before that edge.
- R7: `pwr_status[i]` follows request bit i. It changes only when an accepted write to 0x90 gives that bit a new value, and a write of the same value leaves it untouched.
- R8: An access whose address has bits 1:0 not zero gets a response with `rsp_err` = 1 and `rsp_rdata` = 0, and it changes no register.
- R9: A request is accepted when `req_valid` and `req_ready` are both high, and its response is presented in the following cycle. While `rsp_valid` is high and `rsp_ready` is low, the response data and error flag hold and `req_ready` is low. A write response carries `rsp_rdata` = 0.
- R10: An aligned access to an offset that maps no register reads zero with `rsp_err` = 0, and a write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Misaligned access flag |
| wfi_in | input | 4 | Per-core wait-for-interrupt level |
| pd_ready | output | 4 | Per-core power-down ready (request AND wfi, registered) |
| pwr_status | output | 4 | Per-core power-down request status |
| reset_vec | output | 256 | Four 64-bit boot addresses, core n at bits 64n+63:64n |

## Verification
The bench writes the last upper word at 0x5C and a core in the middle of the map. This catches an off-by-one in the vector decode, which would either overwrite a neighbouring core or let a write into 0x60 land in a register. Writes to the power word with ones in bits 31:4, and a write that repeats the current value, expose a status line that toggles on every write instead of only on a change. The pd_ready checks are timed to the exact edge: a combinational path would show the change one cycle early, and an extra pipeline stage would show it one cycle late. Misaligned writes and a request held against a stalled response catch a design that commits rejected or not-yet-accepted writes, or that lets its response data drift while waiting.

// File: rtl/cc_ctl_pkg.sv
package cc_ctl_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_PWR  = 2'd2
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic       hi;
    logic [7:0] idx;
    logic       aligned;
  } dec_t;

endpackage

// File: rtl/cc_host_port.sv
module cc_host_port
  import cc_ctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int VEC_BASE  = 'h40,
  parameter int PWR_OFS   = 'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic [DATA_W-1:0] rd_data,
  output dec_t              dec,
  output logic              wr_stb
);

  localparam logic [ADDR_W-1:0] VEC_LO  = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] VEC_END = ADDR_W'(VEC_BASE + 8 * NUM_CORES);
  localparam logic [ADDR_W-1:0] PWR_A   = ADDR_W'(PWR_OFS);

  logic              accept;
  logic [ADDR_W-1:0] vec_off;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign vec_off   = req_addr - VEC_LO;

  always_comb begin
    dec         = '0;
    dec.aligned = (req_addr[1:0] == 2'b00);
    if (req_addr >= VEC_LO && req_addr < VEC_END) begin
      dec.sel = SEL_VEC;
      dec.idx = 8'(vec_off >> 3);
      dec.hi  = req_addr[2];
    end else if (req_addr == PWR_A) begin
      dec.sel = SEL_PWR;
    end else begin
      dec.sel = SEL_NONE;
    end
  end

  assign wr_stb = accept && req_write && dec.aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !dec.aligned;
      rsp_rdata <= (req_write || !dec.aligned) ? '0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cc_vec_slot.sv
module cc_vec_slot #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] LO_RST = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= DATA_W'(LO_RST);
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end
  end

endmodule

// File: rtl/cc_pwr_ctl.sv
module cc_pwr_ctl #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_CORES-1:0] wr_bits,
  input  logic [NUM_CORES-1:0] wfi_in,
  output logic [NUM_CORES-1:0] req_q,
  output logic [NUM_CORES-1:0] status_q,
  output logic [NUM_CORES-1:0] pd_ready_q
);

  logic [NUM_CORES-1:0] changed;

  assign changed = wr_en ? (req_q ^ wr_bits) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= '0;
      status_q   <= '0;
      pd_ready_q <= '0;
    end else begin
      if (wr_en) req_q <= wr_bits;
      status_q   <= (status_q & ~changed) | (wr_bits & changed);
      pd_ready_q <= req_q & wfi_in;
    end
  end

endmodule

// File: rtl/cc_core_ctl.sv
module cc_core_ctl
  import cc_ctl_pkg::*;
#(
  parameter int          NUM_CORES = 4,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          VEC_BASE  = 'h40,
  parameter int          PWR_OFS   = 'h90,
  parameter logic [31:0] LO_RST    = 32'hFFFF_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_err,
  input  logic [NUM_CORES-1:0]     wfi_in,
  output logic [NUM_CORES-1:0]     pd_ready,
  output logic [NUM_CORES-1:0]     pwr_status,
  output logic [NUM_CORES*64-1:0]  reset_vec
);

  localparam int VEC_W = 2 * DATA_W;

  dec_t                 dec;
  logic                 wr_stb;
  logic [DATA_W-1:0]    rd_data;
  logic [DATA_W-1:0]    lo_w [NUM_CORES];
  logic [DATA_W-1:0]    hi_w [NUM_CORES];
  logic [NUM_CORES-1:0] req_bits;
  logic                 pwr_wr;

  cc_host_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CORES(NUM_CORES),
    .VEC_BASE (VEC_BASE),
    .PWR_OFS  (PWR_OFS)
  ) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err),
    .rd_data  (rd_data),
    .dec      (dec),
    .wr_stb   (wr_stb)
  );

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
    logic hit;
    assign hit = wr_stb && (dec.sel == SEL_VEC) && (dec.idx == 8'(n));

    cc_vec_slot #(
      .DATA_W(DATA_W),
      .LO_RST(LO_RST)
    ) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_lo(hit && !dec.hi),
      .wr_hi(hit && dec.hi),
      .wdata(req_wdata),
      .lo_q (lo_w[n]),
      .hi_q (hi_w[n])
    );

    assign reset_vec[n*64 +: 64] = 64'({hi_w[n], lo_w[n]});
  end

  assign pwr_wr = wr_stb && (dec.sel == SEL_PWR);

  cc_pwr_ctl #(
    .NUM_CORES(NUM_CORES)
  ) u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (pwr_wr),
    .wr_bits   (req_wdata[NUM_CORES-1:0]),
    .wfi_in    (wfi_in),
    .req_q     (req_bits),
    .status_q  (pwr_status),
    .pd_ready_q(pd_ready)
  );

  always_comb begin
    rd_data = '0;
    unique case (dec.sel)
      SEL_VEC: begin
        for (int n = 0; n < NUM_CORES; n++) begin
          if (dec.idx == 8'(n)) rd_data = dec.hi ? hi_w[n] : lo_w[n];
        end
      end
      SEL_PWR:  rd_data[NUM_CORES-1:0] = req_bits;
      default:  rd_data = '0;
    endcase
  end

  logic unused_w;
  assign unused_w = ^VEC_W;

endmodule

// File: rtl/cc_core_ctl_chk.sv
module cc_core_ctl_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PWR_OFS   = 'h90
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_write,
  input logic [ADDR_W-1:0]       req_addr,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [DATA_W-1:0]       rsp_rdata,
  input logic                    rsp_err,
  input logic [NUM_CORES-1:0]    wfi_in,
  input logic [NUM_CORES-1:0]    pd_ready,
  input logic [NUM_CORES-1:0]    pwr_status,
  input logic [NUM_CORES*64-1:0] reset_vec
);

  logic acc, acc_wr, acc_pwr_wr;
  assign acc        = req_valid && req_ready;
  assign acc_wr     = acc && req_write;
  assign acc_pwr_wr = acc_wr && (req_addr == ADDR_W'(PWR_OFS));

  p_vec_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(reset_vec));

  p_pd_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pd_ready == ($past(pwr_status) & $past(wfi_in)));

  p_status_only_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_pwr_wr |=> $stable(pwr_status));

  p_misalign_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_addr[1:0] != 2'b00) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_rsp_follows_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

endmodule

bind cc_core_ctl cc_core_ctl_chk #(
  .NUM_CORES(NUM_CORES),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PWR_OFS  (PWR_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .wfi_in    (wfi_in),
  .pd_ready  (pd_ready),
  .pwr_status(pwr_status),
  .reset_vec (reset_vec)
);

// File: tb/tb_cc_core_ctl.sv
module tb_cc_core_ctl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [7:0]   req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [31:0]  rsp_rdata;
  logic         rsp_err;
  logic [3:0]   wfi_in = '0;
  logic [3:0]   pd_ready;
  logic [3:0]   pwr_status;
  logic [255:0] reset_vec;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] exp_lo [4];
  logic [31:0] exp_hi [4];

  always #4 clk = ~clk;

  cc_core_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .wfi_in(wfi_in), .pd_ready(pd_ready),
    .pwr_status(pwr_status), .reset_vec(reset_vec)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    er = rsp_err;
    chk("R9 response valid after accept", 64'(rsp_valid), 64'd1);
  endtask

  task automatic chk_all_vecs(input string tag);
    for (int n = 0; n < 4; n++)
      chk(tag, reset_vec[n*64 +: 64], {exp_hi[n], exp_lo[n]});
  endtask

  task automatic t_reset;
    for (int n = 0; n < 4; n++) begin
      exp_lo[n] = 32'hFFFF_0000;
      exp_hi[n] = 32'h0;
    end
    chk_all_vecs("R1 reset vector");
    chk("R1 pd_ready", 64'(pd_ready), 64'h0);
    chk("R1 pwr_status", 64'(pwr_status), 64'h0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R1 req_ready", 64'(req_ready), 64'h1);
  endtask

  task automatic t_vectors;
    logic [31:0] rd; logic er;
    access(1'b1, 8'h40, 32'h1000_0040, rd, er); exp_lo[0] = 32'h1000_0040;
    chk("R3 core0 after low write", reset_vec[63:0], {exp_hi[0], exp_lo[0]});
    access(1'b1, 8'h54, 32'hABCD_0012, rd, er); exp_hi[2] = 32'hABCD_0012;
    chk("R3 core2 after high write", reset_vec[191:128], {exp_hi[2], exp_lo[2]});
    access(1'b1, 8'h5C, 32'h0000_0077, rd, er); exp_hi[3] = 32'h0000_0077;
    access(1'b1, 8'h48, 32'h2222_1110, rd, er); exp_lo[1] = 32'h2222_1110;
    chk_all_vecs("R4 each core holds own words");
    access(1'b0, 8'h5C, 32'h0, rd, er);
    chk("R2 read core3 high at 0x5C", 64'(rd), 64'h77);
    access(1'b0, 8'h50, 32'h0, rd, er);
    chk("R2 read core2 low at 0x50", 64'(rd), 64'hFFFF_0000);
    access(1'b0, 8'h48, 32'h0, rd, er);
    chk("R2 read core1 low at 0x48", 64'(rd), 64'h2222_1110);
    access(1'b0, 8'h44, 32'h0, rd, er);
    chk("R2 read core0 high at 0x44", 64'(rd), 64'h0);
  endtask

  task automatic t_power;
    logic [31:0] rd; logic er;
    access(1'b1, 8'h90, 32'hFFFF_FFF5, rd, er);
    chk("R9 write response data zero", 64'(rd), 64'h0);
    chk("R7 status after write", 64'(pwr_status), 64'h5);
    chk_all_vecs("R4 vectors untouched by power write");
    access(1'b0, 8'h90, 32'h0, rd, er);
    chk("R5 upper bits read zero", 64'(rd), 64'h5);
    access(1'b1, 8'h90, 32'h0000_0005, rd, er);
    chk("R7 same value keeps status", 64'(pwr_status), 64'h5);
    access(1'b1, 8'h90, 32'h0000_0006, rd, er);
    chk("R7 status after change", 64'(pwr_status), 64'h6);
    chk("R6 no wfi no ready", 64'(pd_ready), 64'h0);
  endtask

  task automatic t_pdr;
    logic [31:0] rd; logic er;
    @(negedge clk);
    wfi_in = 4'hF;
    chk("R6 not combinational", 64'(pd_ready), 64'h0);
    @(negedge clk);
    chk("R6 one edge after wfi", 64'(pd_ready), 64'h6);
    access(1'b1, 8'h90, 32'h0000_0009, rd, er);
    chk("R6 old value right after write", 64'(pd_ready), 64'h6);
    @(negedge clk);
    chk("R6 new value one edge later", 64'(pd_ready), 64'h9);
    wfi_in = 4'h1;
    @(negedge clk);
    chk("R6 follows wfi drop", 64'(pd_ready), 64'h1);
    wfi_in = 4'h0;
    @(negedge clk);
    chk("R6 all low", 64'(pd_ready), 64'h0);
  endtask

  task automatic t_misalign;
    logic [31:0] rd; logic er;
    access(1'b1, 8'h42, 32'hDEAD_BEEF, rd, er);
    chk("R8 misaligned write err", 64'(er), 64'h1);
    chk_all_vecs("R8 misaligned write no effect");
    access(1'b1, 8'h92, 32'h0000_0000, rd, er);
    chk("R8 misaligned power write no effect", 64'(pwr_status), 64'h9);
    access(1'b0, 8'h49, 32'h0, rd, er);
    chk("R8 misaligned read err", 64'(er), 64'h1);
    chk("R8 misaligned read data", 64'(rd), 64'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] rd; logic er;
    access(1'b1, 8'h60, 32'h1234_5678, rd, er);
    access(1'b1, 8'h3C, 32'h1234_5678, rd, er);
    access(1'b1, 8'h8C, 32'h0000_0000, rd, er);
    chk_all_vecs("R10 unmapped writes ignored");
    chk("R10 status after unmapped write", 64'(pwr_status), 64'h9);
    access(1'b0, 8'h60, 32'h0, rd, er);
    chk("R10 unmapped read zero", 64'(rd), 64'h0);
    chk("R10 unmapped read no err", 64'(er), 64'h0);
    access(1'b0, 8'h94, 32'h0, rd, er);
    chk("R10 unmapped read 0x94", 64'(rd), 64'h0);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h48;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 response presented", 64'(rsp_valid), 64'h1);
    chk("R9 read data", 64'(rsp_rdata), 64'h2222_1110);
    chk("R9 ready low while stalled", 64'(req_ready), 64'h0);
    held = rsp_rdata;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h4C; req_wdata = 32'h5A5A_0001;
    @(negedge clk);
    chk("R9 response held", 64'(rsp_valid), 64'h1);
    chk("R9 data held", 64'(rsp_rdata), 64'(held));
    chk("R9 stalled write not taken", reset_vec[127:64], {exp_hi[1], exp_lo[1]});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_hi[1] = 32'h5A5A_0001;
    chk("R9 write taken after release", reset_vec[127:64], {exp_hi[1], exp_lo[1]});
    chk("R9 write response present", 64'(rsp_valid), 64'h1);
    chk("R9 write response data", 64'(rsp_rdata), 64'h0);
    @(negedge clk);
    chk("R9 response consumed", 64'(rsp_valid), 64'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_power();
    t_pdr();
    t_misalign();
    t_unmapped();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule